// File: doc/BRIEF.md
# Serial Control Register Write Port

This block is the write side of a three-wire control port: a chip-select line, a serial clock and a serial data line. The external host lowers chip select, clocks in one 16-bit frame and raises chip select again. The frame carries a 3-bit command, a 5-bit register address and an 8-bit value. The address and the value are each shifted in least significant bit first. The block keeps four 8-bit configuration registers and presents their decoded fields to the surrounding audio front end.

All three serial lines are brought into the system clock domain through a two-flop stage, and their edges are found there. A frame is only committed when chip select rises, and only if it held exactly sixteen serial clock rising edges and a write command.

Some writes are refused depending on the state of the block:
- A low level on the power-down pin reloads the reset image and refuses every write.
- A running offset calibration locks the power register.
- The power bits in that register gate the format register and the gain register.

There is no readback path.

Top module: `ctrl_reg_port`

## Requirements
- R1: Frame bit k (k = 0 first on the wire) maps as follows: bits 0 to 2 are command bits c0, c1 and c2; bits 3 to 7 are address bits a0 to a4; bits 8 to 15 are data bits d0 to d7. An accepted frame copies d7..d0 into the addressed register.
- R2: The register image does not change while chip select is low. It changes only after chip select rises, and it is updated within 8 system clock cycles of that rise.
- R3: A frame is discarded when chip select rises if it held any number of serial clock rising edges other than 16 (for example 15 or 17).
- R4: A frame is a write only if command bit c2 is 1; c0 and c1 may take any value. A frame with c2 = 0 changes nothing.
- R5: Addresses 04h to 1Fh are ignored and change no register.
- R6: After the system reset, registers 00h, 01h, 02h and 03h hold 05h, 03h, 30h and 00h.
- R7: While pdn_n is low, all four registers hold their reset values, and frames committed in that time change nothing.
- R8: While cal_busy is 1, a write to 01h is refused. Writes to 00h, 02h and 03h are still allowed.
- R9: A write to 02h is refused while bit 1 of 01h (ADC power) is 0.
- R10: A write to 03h is refused while bit 0 of 01h (PGA power) is 0.
- R11: Serial clock edges while chip select is high are ignored. Each fall of chip select starts a new frame with an empty bit count, so an aborted frame does not carry over into the next one.
- R12: The fields are decoded from these register bits:
  - 00h: bits 1:0 are the left input select, bits 3:2 are the right input select, and bit 4 is the high-pass filter bypass.
  - 01h: bit 0 is PGA power and bit 1 is ADC power.
  - 02h: bit 1 selects the I2S format, bits 5:4 are the zero-cross timeout select, and bits 7:6 are the mono mode.
  - 03h: bits 6:0 are the PGA gain code and bit 7 is the zero-cross enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| pdn_n | input | 1 | Power-down pin, low reloads and locks the registers (synchronous to clk) |
| cal_busy | input | 1 | Offset calibration running (synchronous to clk) |
| csn | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data in |
| cfg_image | output | 32 | Register n at bits 8n+7:8n |
| in_left_sel | output | 2 | Left input select |
| in_right_sel | output | 2 | Right input select |
| hpf_off | output | 1 | High-pass filter bypass |
| pga_power | output | 1 | PGA power enable |
| adc_power | output | 1 | ADC power enable |
| fmt_i2s | output | 1 | Serial audio format select |
| zc_timeout_sel | output | 2 | Zero-cross timeout select |
| mono_mode | output | 2 | Mono mixing mode |
| pga_gain | output | 7 | PGA gain code |
| zc_enable | output | 1 | Zero-cross gain change enable |

## Verification
The frames vary the command bits, so that writes that differ only in the don't-care bits, and writes with c2 cleared, can be told apart. The addresses run over all four registers and over out-of-range values such as 04h and 1Fh. The edge counts are 15, 16 and 17, which separates an exact count from a "sixteen or more" decoder.

The power register is walked through its combinations, with calibration both asserted and released, so that each per-address lock is shown to hit only its own register. Directed cases probe the image just before chip select rises, send clock pulses while the port is idle, abort a frame part way, and hold the power-down pin low while a frame is sent.

// File: rtl/ctrl_reg_pkg.sv
// Shared constants for the serial control register port: frame geometry,
// register addresses, bit positions of the power controls and reset image.
package ctrl_reg_pkg;
    localparam int FRAME_BITS = 16;
    localparam int OP_BITS    = 3;
    localparam int ADDR_BITS  = 5;
    localparam int DATA_BITS  = 8;
    localparam int NUM_REGS   = 4;
    localparam int SYNC_STAGES = 2;

    // register indices whose write rules differ
    localparam int ADR_SEL  = 0;
    localparam int ADR_PWR  = 1;
    localparam int ADR_FMT  = 2;
    localparam int ADR_GAIN = 3;

    // bit positions inside the power register
    localparam int PWR_PGA_BIT = 0;
    localparam int PWR_ADC_BIT = 1;

    // reset image, register n at bits 8n+7:8n
    localparam logic [NUM_REGS*DATA_BITS-1:0] RST_IMAGE = 32'h0030_0305;

    // Per-address write permission under calibration and power state.
    function automatic logic wr_permitted(input int idx, input logic cal,
                                          input logic pga_on, input logic adc_on);
        logic ok;
        ok = 1'b1;
        if (idx == ADR_PWR  && cal)     ok = 1'b0;
        if (idx == ADR_FMT  && !adc_on) ok = 1'b0;
        if (idx == ADR_GAIN && !pga_on) ok = 1'b0;
        return ok;
    endfunction
endpackage

// File: rtl/crp_sync.sv
// Multi-bit flop-chain synchronizer into the system clock domain.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module crp_sync #(
    parameter int                WIDTH  = 3,
    parameter int                STAGES = 2,
    parameter logic [WIDTH-1:0]  IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first capture of the asynchronous inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= IDLE;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            // further settling stages
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= IDLE;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/crp_frame_rx.sv
// Frame receiver: detects serial clock and chip-select edges on synchronized
// levels, shifts data LSB-first, counts clock edges and issues a one-cycle
// write strobe on chip-select rise when the frame is a valid write.
// Assumes the serial clock is slow enough for every level to last >= 2 clocks.
module crp_frame_rx #(
    parameter int FRAME_BITS = 16,
    parameter int OP_BITS    = 3,
    parameter int ADDR_BITS  = 5,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_s,
    input  logic                 sck_s,
    input  logic                 sd_s,
    output logic                 wr_stb,
    output logic [ADDR_BITS-1:0] wr_addr,
    output logic [DATA_BITS-1:0] wr_data
);
    // the first OP_BITS-1 command bits are don't-care and fall off the end
    localparam int SR_W    = FRAME_BITS - OP_BITS + 1;
    localparam int CNT_MAX = FRAME_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int A_LO    = 1;
    localparam int D_LO    = 1 + ADDR_BITS;

    logic             cs_d, sck_d;
    logic             sck_rise, cs_rise, frame_ok;
    logic [SR_W-1:0]  sr_q;
    logic [CNT_W-1:0] cnt_q;

    // edge history of the synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_n_s;
            sck_d <= sck_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign cs_rise  = cs_n_s & ~cs_d;

    // shift register and saturating edge count, emptied while deselected
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (sck_rise) begin
            sr_q <= {sd_s, sr_q[SR_W-1:1]};
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame_ok = cs_rise && (cnt_q == CNT_W'(FRAME_BITS)) && sr_q[0];

    // registered commit strobe with latched address and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= frame_ok;
            if (frame_ok) begin
                wr_addr <= sr_q[A_LO +: ADDR_BITS];
                wr_data <= sr_q[D_LO +: DATA_BITS];
            end
        end
    end

    // R3
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(cnt_q) == CNT_W'(FRAME_BITS));
    // R4
    write_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(sr_q[0]));
    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> cnt_q == '0);
endmodule

// File: rtl/crp_reg_bank.sv
// Register bank: holds NUM_REGS bytes, applies the reset image on system
// reset or power-down pin, and filters each write by address and by the
// calibration and power state. Assumes pdn_n and cal_busy are synchronous.
module crp_reg_bank
    import ctrl_reg_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int ABITS  = ADDR_BITS,
    parameter int DBITS  = DATA_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pdn_n,
    input  logic                    cal_busy,
    input  logic                    wr_stb,
    input  logic [ABITS-1:0]        wr_addr,
    input  logic [DBITS-1:0]        wr_data,
    output logic [N_REGS*DBITS-1:0] image
);
    logic [DBITS-1:0] regs_q [N_REGS];
    logic             pga_on, adc_on;

    assign pga_on = regs_q[ADR_PWR][PWR_PGA_BIT];
    assign adc_on = regs_q[ADR_PWR][PWR_ADC_BIT];

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        logic allow;

        // decide whether the pending write lands in this register
        always_comb begin
            allow = wr_stb && pdn_n && (wr_addr == ABITS'(i))
                    && wr_permitted(i, cal_busy, pga_on, adc_on);
        end

        // storage with reset image on either reset source
        always_ff @(posedge clk) begin
            if (!rst_n || !pdn_n) regs_q[i] <= RST_IMAGE[i*DBITS +: DBITS];
            else if (allow)       regs_q[i] <= wr_data;
        end

        assign image[i*DBITS +: DBITS] = regs_q[i];
    end

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && pdn_n) |=> $stable(image));
    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && pdn_n && wr_addr >= ABITS'(N_REGS)) |=> $stable(image));
    // R7
    pdn_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> image == RST_IMAGE);
    // R8
    cal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && pdn_n && cal_busy && wr_addr == ABITS'(ADR_PWR))
        |=> $stable(regs_q[ADR_PWR]));
    // R9
    adc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && pdn_n && !adc_on && wr_addr == ABITS'(ADR_FMT))
        |=> $stable(regs_q[ADR_FMT]));
    // R10
    pga_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && pdn_n && !pga_on && wr_addr == ABITS'(ADR_GAIN))
        |=> $stable(regs_q[ADR_GAIN]));
endmodule

// File: rtl/ctrl_reg_port.sv
// Top of the three-wire write-only control port: synchronizes the serial
// lines, receives frames and keeps the configuration registers, then splits
// the register image into named fields. No readback path.
module ctrl_reg_port
    import ctrl_reg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pdn_n,
    input  logic        cal_busy,
    input  logic        csn,
    input  logic        sclk,
    input  logic        sdi,
    output logic [31:0] cfg_image,
    output logic [1:0]  in_left_sel,
    output logic [1:0]  in_right_sel,
    output logic        hpf_off,
    output logic        pga_power,
    output logic        adc_power,
    output logic        fmt_i2s,
    output logic [1:0]  zc_timeout_sel,
    output logic [1:0]  mono_mode,
    output logic [6:0]  pga_gain,
    output logic        zc_enable
);
    localparam int IMG_W = NUM_REGS * DATA_BITS;

    logic [2:0]           pins_s;
    logic                 wr_stb;
    logic [ADDR_BITS-1:0] wr_addr;
    logic [DATA_BITS-1:0] wr_data;
    logic [IMG_W-1:0]     image;
    logic [DATA_BITS-1:0] r_sel, r_pwr, r_fmt, r_gain;

    // bit order {sdi, sclk, csn}; chip select idles high
    crp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(3'b001)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdi, sclk, csn}),
        .dout (pins_s)
    );

    crp_frame_rx #(
        .FRAME_BITS(FRAME_BITS), .OP_BITS(OP_BITS),
        .ADDR_BITS(ADDR_BITS),   .DATA_BITS(DATA_BITS)
    ) i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_s (pins_s[0]),
        .sck_s  (pins_s[1]),
        .sd_s   (pins_s[2]),
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    crp_reg_bank #(.N_REGS(NUM_REGS), .ABITS(ADDR_BITS), .DBITS(DATA_BITS)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn_n   (pdn_n),
        .cal_busy(cal_busy),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .image   (image)
    );

    assign cfg_image = image;
    assign r_sel  = image[ADR_SEL*DATA_BITS  +: DATA_BITS];
    assign r_pwr  = image[ADR_PWR*DATA_BITS  +: DATA_BITS];
    assign r_fmt  = image[ADR_FMT*DATA_BITS  +: DATA_BITS];
    assign r_gain = image[ADR_GAIN*DATA_BITS +: DATA_BITS];

    // field decode
    assign in_left_sel    = r_sel[1:0];
    assign in_right_sel   = r_sel[3:2];
    assign hpf_off        = r_sel[4];
    assign pga_power      = r_pwr[PWR_PGA_BIT];
    assign adc_power      = r_pwr[PWR_ADC_BIT];
    assign fmt_i2s        = r_fmt[1];
    assign zc_timeout_sel = r_fmt[5:4];
    assign mono_mode      = r_fmt[7:6];
    assign pga_gain       = r_gain[6:0];
    assign zc_enable      = r_gain[7];
endmodule

// File: tb/test_ctrl_reg_port.sv
`timescale 1ns/1ps
module test_ctrl_reg_port;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, pdn_n, cal_busy, csn, sclk, sdi;
    logic [31:0] cfg_image;
    logic [1:0]  in_left_sel, in_right_sel, zc_timeout_sel, mono_mode;
    logic        hpf_off, pga_power, adc_power, fmt_i2s, zc_enable;
    logic [6:0]  pga_gain;

    ctrl_reg_port i_ctrl_reg_port (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .cal_busy(cal_busy),
        .csn(csn), .sclk(sclk), .sdi(sdi), .cfg_image(cfg_image),
        .in_left_sel(in_left_sel), .in_right_sel(in_right_sel), .hpf_off(hpf_off),
        .pga_power(pga_power), .adc_power(adc_power), .fmt_i2s(fmt_i2s),
        .zc_timeout_sel(zc_timeout_sel), .mono_mode(mono_mode),
        .pga_gain(pga_gain), .zc_enable(zc_enable)
    );

    localparam logic [31:0] RST_IMG = 32'h0030_0305;
    localparam int NV = 18;
    // {command c2..c0, address, data, edge count, cal_busy}
    localparam logic [21:0] VEC [NV] = '{
        {3'b100, 5'h00, 8'hA6, 5'd16, 1'b0},
        {3'b100, 5'h03, 8'h55, 5'd16, 1'b0},
        {3'b100, 5'h02, 8'hC2, 5'd16, 1'b0},
        {3'b011, 5'h00, 8'h11, 5'd16, 1'b0},
        {3'b111, 5'h00, 8'h3C, 5'd16, 1'b0},
        {3'b100, 5'h04, 8'hFF, 5'd16, 1'b0},
        {3'b100, 5'h1F, 8'h00, 5'd16, 1'b0},
        {3'b100, 5'h00, 8'h00, 5'd15, 1'b0},
        {3'b100, 5'h00, 8'h00, 5'd17, 1'b0},
        {3'b100, 5'h01, 8'h00, 5'd16, 1'b1},
        {3'b100, 5'h00, 8'h5A, 5'd16, 1'b1},
        {3'b100, 5'h01, 8'h02, 5'd16, 1'b0},
        {3'b100, 5'h03, 8'h7F, 5'd16, 1'b0},
        {3'b100, 5'h02, 8'h10, 5'd16, 1'b0},
        {3'b100, 5'h01, 8'h01, 5'd16, 1'b0},
        {3'b100, 5'h02, 8'hFF, 5'd16, 1'b0},
        {3'b100, 5'h03, 8'h9F, 5'd16, 1'b0},
        {3'b100, 5'h01, 8'h03, 5'd16, 1'b0}
    };

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_q [4];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_img();
        return {exp_q[3], exp_q[2], exp_q[1], exp_q[0]};
    endfunction

    function automatic void exp_reset();
        for (int i = 0; i < 4; i++) exp_q[i] = RST_IMG[i*8 +: 8];
    endfunction

    // independent write-rule model
    function automatic void model(input logic [2:0] op, input logic [4:0] adr,
                                  input logic [7:0] dat, input int edges, input logic cal);
        if (pdn_n && edges == 16 && op[2] && adr < 5'd4) begin
            if (adr == 5'd0) exp_q[0] = dat;
            if (adr == 5'd1 && !cal) exp_q[1] = dat;
            if (adr == 5'd2 && exp_q[1][1]) exp_q[2] = dat;
            if (adr == 5'd3 && exp_q[1][0]) exp_q[3] = dat;
        end
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [4:0] adr,
                                     input int edges, input logic cal);
        if (edges != 16) return "R3";
        if (!op[2]) return "R4";
        if (adr > 5'd3) return "R5";
        if (adr == 5'd1 && cal) return "R8";
        if (adr == 5'd2 && !exp_q[1][1]) return "R9";
        if (adr == 5'd3 && !exp_q[1][0]) return "R10";
        return "R1";
    endfunction

    // frame body: csn low, edges clocked; csn left low
    task automatic send(input logic [2:0] op, input logic [4:0] adr,
                        input logic [7:0] dat, input int edges);
        logic [15:0] fr;
        fr = {dat, adr, op};
        csn = 1'b0;
        tick(4);
        for (int i = 0; i < edges; i++) begin
            sdi = (i < 16) ? fr[i] : 1'b0;
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
        tick(4);
    endtask

    task automatic release_cs();
        csn = 1'b1;
        tick(8);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pdn_n = 1'b1; cal_busy = 1'b0;
        csn = 1'b1; sclk = 1'b0; sdi = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        exp_reset();
        check("R6", cfg_image, exp_img());

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [2:0] op;
            logic [4:0] adr;
            logic [7:0] dat;
            int edges;
            logic cal;
            string tag;
            {op, adr, dat} = VEC[v][21:6];
            edges = int'(VEC[v][5:1]);
            cal = VEC[v][0];
            tag = tag_of(op, adr, edges, cal);
            cal_busy = cal;
            send(op, adr, dat, edges);
            release_cs();
            cal_busy = 1'b0;
            model(op, adr, dat, edges, cal);
            check(tag, cfg_image, exp_img());
        end

        // R12 field positions
        check("R12",
              {10'd0, zc_enable, pga_gain, mono_mode, zc_timeout_sel, fmt_i2s,
               adc_power, pga_power, hpf_off, in_right_sel, in_left_sel},
              {10'd0, exp_q[3][7], exp_q[3][6:0], exp_q[2][7:6], exp_q[2][5:4],
               exp_q[2][1], exp_q[1][1], exp_q[1][0], exp_q[0][4],
               exp_q[0][3:2], exp_q[0][1:0]});

        // R2: no change before chip select rises
        send(3'b100, 5'h00, 8'h99, 16);
        check("R2", cfg_image, exp_img());
        release_cs();
        model(3'b100, 5'h00, 8'h99, 16, 1'b0);
        check("R2", cfg_image, exp_img());

        // R11: idle clock pulses, then a normal frame
        sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
        end
        tick(8);
        check("R11", cfg_image, exp_img());
        send(3'b100, 5'h03, 8'h44, 16);
        release_cs();
        model(3'b100, 5'h03, 8'h44, 16, 1'b0);
        check("R11", cfg_image, exp_img());

        // R11: aborted frame does not pollute the next one
        send(3'b100, 5'h01, 8'hFF, 7);
        release_cs();
        check("R11", cfg_image, exp_img());
        send(3'b100, 5'h00, 8'h0F, 16);
        release_cs();
        model(3'b100, 5'h00, 8'h0F, 16, 1'b0);
        check("R11", cfg_image, exp_img());

        // R7: power-down pin reloads and blocks
        pdn_n = 1'b0;
        tick(3);
        exp_reset();
        check("R7", cfg_image, exp_img());
        send(3'b100, 5'h00, 8'hEE, 16);
        release_cs();
        check("R7", cfg_image, exp_img());
        pdn_n = 1'b1;
        tick(2);
        send(3'b100, 5'h03, 8'h20, 16);
        release_cs();
        model(3'b100, 5'h03, 8'h20, 16, 1'b0);
        check("R1", cfg_image, exp_img());

        done = 1'b1;
        summary();
        $finish;
    end
endmodule